// File: doc/BRIEF.md
# Initiator Information Transfer Controller

This block runs one information-transfer command for a bus controller that is already connected to a target as initiator. The target drives REQ and the phase lines: command/data, message and direction. The block answers each REQ with ACK, one byte at a time, and moves the bytes through a small FIFO that the host fills or drains. A transfer-count register counts the bytes down. Every outcome is reported as a one-cycle interrupt pulse with a code: service required, successful completion, paused, terminated or bus free.

The host loads the count, or sets the single-byte option, and pulses the command strobe once the target shows the phase it wants. The block latches that phase and transfers until the count reaches zero. It stops early if the target changes phase or if a received byte fails the odd-parity check while halting on parity is enabled. It also stops if the target drops BSY or the host disconnects. A message-in transfer ends with ACK still high, so the host can raise ATN before it lets the byte go.

Top module: `xfer_info_ctl`

## Requirements
- R1: After reset the block is disconnected, ACK and ATN are low, no interrupt is pending, and the buffer-ready flag is 1 (the direction is out and the FIFO is empty).
- R2: In the connected-waiting state, the first REQ raises a service-required pulse (code 1) on the next clock edge and latches the phase shown on the bus.
- R3: A command with the single-byte option set moves exactly one byte, whatever was loaded before. Without the option, it moves the loaded count.
- R4: The buffer-ready flag means "FIFO not full" while the latched direction line (bit 0 of {cd,msg,io}) is 0, which is an out phase. It means "FIFO not empty" while that line is 1, which is an in phase.
- R5: When a non-message-in transfer exhausts its count, ACK drops. Successful completion (code 2) comes only on the edge after the target next asserts REQ.
- R6: When a message-in transfer (phase {cd,msg,io} = 111) exhausts its count, ACK stays high and paused (code 3) is raised. ACK stays high until the ACK-release strobe. The ATN output follows the host ATN input one cycle later.
- R7: A REQ whose phase differs from the latched phase before the count is exhausted raises terminated (code 4). No byte moves, and the count keeps the number of bytes still to move.
- R8: A received byte with bad odd parity, with halt enabled, is not stored or counted. ACK rises and stays high. Terminated (code 4) is raised one edge after the host has emptied the FIFO.
- R9: A bad-parity byte with halt disabled sets a sticky parity-error flag and the transfer goes on. The flag clears on the next command strobe.
- R10: If the target drops BSY while connected, the block goes to disconnected and raises bus free (code 5). A disconnect strobe also goes to disconnected, but raises no interrupt.
- R11: In an in phase, a full FIFO holds off ACK until the host reads a byte. In an out phase, an empty FIFO holds off data and ACK until the host writes one.
- R12: In an out phase, the byte and its odd-parity bit are driven with the output enable one cycle before ACK rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conn_i | input | 1 | Strobe: now connected as initiator |
| cmd_go | input | 1 | Strobe: start the transfer-info command |
| cmd_single | input | 1 | Single-byte option qualifying cmd_go |
| cmd_disc | input | 1 | Strobe: disconnect command |
| ack_rel | input | 1 | Strobe: release a held ACK |
| halt_par_en | input | 1 | Halt on receive parity error |
| host_atn | input | 1 | Host request to assert ATN |
| cnt_ld | input | 1 | Load the transfer count (not while transferring) |
| cnt_in | input | CNT_W | Transfer count to load |
| cnt_out | output | CNT_W | Bytes still to transfer |
| h_wr | input | 1 | Host FIFO write |
| h_wdata | input | DW | Host write data |
| h_rd | input | 1 | Host FIFO read |
| h_rdata | output | DW | FIFO head for the host |
| dbr | output | 1 | Data-buffer-ready flag |
| par_err | output | 1 | Sticky parity-error flag |
| irq_v | output | 1 | Interrupt pulse |
| irq_code | output | 3 | Interrupt code (1 svc, 2 done, 3 paused, 4 terminated, 5 bus free) |
| connected | output | 1 | Block is connected |
| req_i | input | 1 | Target REQ (already synchronized) |
| bsy_i | input | 1 | BSY |
| cd_i | input | 1 | Command/data phase line |
| msg_i | input | 1 | Message phase line |
| io_i | input | 1 | Direction phase line (1 = in) |
| db_i | input | DW | Bus data in |
| dbp_i | input | 1 | Bus parity in |
| ack_o | output | 1 | ACK |
| atn_o | output | 1 | ATN |
| db_o | output | DW | Bus data out |
| dbp_o | output | 1 | Bus parity out |
| db_oe | output | 1 | Bus data output enable |

## Verification
All bus and host inputs are sampled on the clock edge, and every result is a register. So an interrupt pulse, a change in ACK, or a new count shows up one edge after the stimulus that causes it. The one exception is an out byte: its data appears one edge after REQ, and ACK one edge after that. The bench drives inputs just after an edge, advances exactly the number of edges each result needs, and checks the outputs between edges. For hold-off cases it also checks that nothing changed on the edges where the block must wait: a full or empty FIFO, a missing next REQ, or a pending ACK release.

// File: rtl/xi_pkg.sv
package xi_pkg;
   typedef enum logic [3:0] {
      S_DISC, S_WAIT1, S_IDLE, S_XFER, S_SETUP,
      S_ACK, S_DONE, S_PAUSE, S_PHALT, S_PHELD
   } xi_state_t;

   typedef enum logic [2:0] {
      IRQ_NONE  = 3'd0,
      IRQ_SVC   = 3'd1,
      IRQ_DONE  = 3'd2,
      IRQ_PAUSE = 3'd3,
      IRQ_TERM  = 3'd4,
      IRQ_BFREE = 3'd5
   } xi_irq_t;

   localparam logic [2:0] PH_MSG_IN = 3'b111;
endpackage

// File: rtl/xi_parity.sv
module xi_parity #(
   parameter int DW  = 8,
   parameter bit ODD = 1'b1
) (
   input  logic [DW-1:0] data,
   output logic          pbit
);
   generate
      if (ODD) begin : g_odd
         assign pbit = ~^data;
      end else begin : g_even
         assign pbit = ^data;
      end
   endgenerate
endmodule

// File: rtl/xi_fifo.sv
module xi_fifo #(
   parameter int DW    = 8,
   parameter int DEPTH = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          wr,
   input  logic [DW-1:0] wdata,
   input  logic          rd,
   output logic [DW-1:0] rdata,
   output logic          full,
   output logic          empty
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("xi_fifo: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [DW-1:0] mem [DEPTH];
   logic [AW:0]   wp, rp;

   assign empty = (wp == rp);
   assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
   assign rdata = mem[rp[AW-1:0]];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp <= '0;
         rp <= '0;
      end else if (clr) begin
         wp <= '0;
         rp <= '0;
      end else begin
         if (wr) wp <= wp + 1'b1;
         if (rd) rp <= rp + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr && !clr) mem[wp[AW-1:0]] <= wdata;
   end

   AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && full)); // R11
   AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd && empty)); // R11
endmodule

// File: rtl/xfer_info_ctl.sv
module xfer_info_ctl #(
   parameter int DW      = 8,
   parameter int DEPTH   = 4,
   parameter int CNT_W   = 16,
   parameter bit PAR_ODD = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             conn_i,
   input  logic             cmd_go,
   input  logic             cmd_single,
   input  logic             cmd_disc,
   input  logic             ack_rel,
   input  logic             halt_par_en,
   input  logic             host_atn,
   input  logic             cnt_ld,
   input  logic [CNT_W-1:0] cnt_in,
   output logic [CNT_W-1:0] cnt_out,
   input  logic             h_wr,
   input  logic [DW-1:0]    h_wdata,
   input  logic             h_rd,
   output logic [DW-1:0]    h_rdata,
   output logic             dbr,
   output logic             par_err,
   output logic             irq_v,
   output logic [2:0]       irq_code,
   output logic             connected,
   input  logic             req_i,
   input  logic             bsy_i,
   input  logic             cd_i,
   input  logic             msg_i,
   input  logic             io_i,
   input  logic [DW-1:0]    db_i,
   input  logic             dbp_i,
   output logic             ack_o,
   output logic             atn_o,
   output logic [DW-1:0]    db_o,
   output logic             dbp_o,
   output logic             db_oe
);
   import xi_pkg::*;

   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   generate
      if (CNT_W < 2 || DW < 1) begin : g_bad_width
         $error("xfer_info_ctl: CNT_W must be at least 2 and DW at least 1");
      end
   endgenerate

   xi_state_t        st;
   logic [2:0]       ph_q;
   logic [CNT_W-1:0] cnt;
   logic             ack_q, oe_q, perr_q, irq_q, atn_q;
   xi_irq_t          irq_c;
   logic [DW-1:0]    dout_q;
   logic             pout_q;

   logic [2:0]    ph_bus;
   logic          dir_in, ph_ok, abort;
   logic          f_full, f_empty, f_wr, f_rd, bus_push, bus_pop;
   logic [DW-1:0] f_wd, f_rdata;
   logic          rx_exp_par, rx_bad, tx_par;

   assign ph_bus = {cd_i, msg_i, io_i};
   assign dir_in = ph_q[0];
   assign ph_ok  = (ph_bus == ph_q);
   assign abort  = cmd_disc || !bsy_i;

   xi_parity #(.DW(DW), .ODD(PAR_ODD)) u_rx_par (.data(db_i),    .pbit(rx_exp_par));
   xi_parity #(.DW(DW), .ODD(PAR_ODD)) u_tx_par (.data(f_rdata), .pbit(tx_par));
   assign rx_bad = (rx_exp_par != dbp_i);

   assign bus_push = (st == S_XFER) && req_i && ph_ok && dir_in && !f_full &&
                     !(rx_bad && halt_par_en) && !abort;
   assign bus_pop  = (st == S_XFER) && req_i && ph_ok && !dir_in && !f_empty && !abort;

   assign f_wr = dir_in ? bus_push : (h_wr && !f_full);
   assign f_wd = dir_in ? db_i : h_wdata;
   assign f_rd = dir_in ? (h_rd && !f_empty) : bus_pop;

   xi_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (st == S_DISC),
      .wr    (f_wr),
      .wdata (f_wd),
      .rd    (f_rd),
      .rdata (f_rdata),
      .full  (f_full),
      .empty (f_empty)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= S_DISC;
         ph_q   <= '0;
         cnt    <= '0;
         ack_q  <= 1'b0;
         oe_q   <= 1'b0;
         dout_q <= '0;
         pout_q <= 1'b0;
         perr_q <= 1'b0;
         irq_q  <= 1'b0;
         irq_c  <= IRQ_NONE;
         atn_q  <= 1'b0;
      end else begin
         irq_q <= 1'b0;
         atn_q <= host_atn && (st != S_DISC);
         if (cnt_ld && (st inside {S_DISC, S_WAIT1, S_IDLE, S_DONE})) cnt <= cnt_in;
         if (st != S_DISC && cmd_disc) begin
            st    <= S_DISC;
            ack_q <= 1'b0;
            oe_q  <= 1'b0;
         end else if (st != S_DISC && !bsy_i) begin
            st    <= S_DISC;
            ack_q <= 1'b0;
            oe_q  <= 1'b0;
            irq_q <= 1'b1;
            irq_c <= IRQ_BFREE;
         end else begin
            unique case (st)
               S_DISC: if (conn_i) st <= S_WAIT1;
               S_WAIT1: if (req_i) begin
                  st    <= S_IDLE;
                  ph_q  <= ph_bus;
                  irq_q <= 1'b1;
                  irq_c <= IRQ_SVC;
               end
               S_IDLE: if (cmd_go) begin
                  st     <= S_XFER;
                  ph_q   <= ph_bus;
                  perr_q <= 1'b0;
                  if (cmd_single) cnt <= CNT_ONE;
               end
               S_XFER: if (req_i) begin
                  if (!ph_ok) begin
                     st    <= S_IDLE;
                     ph_q  <= ph_bus;
                     irq_q <= 1'b1;
                     irq_c <= IRQ_TERM;
                  end else if (dir_in) begin
                     if (!f_full) begin
                        if (rx_bad) perr_q <= 1'b1;
                        ack_q <= 1'b1;
                        st    <= (rx_bad && halt_par_en) ? S_PHALT : S_ACK;
                     end
                  end else if (!f_empty) begin
                     dout_q <= f_rdata;
                     pout_q <= tx_par;
                     oe_q   <= 1'b1;
                     st     <= S_SETUP;
                  end
               end
               S_SETUP: begin
                  ack_q <= 1'b1;
                  st    <= S_ACK;
               end
               S_ACK: if (!req_i) begin
                  cnt <= cnt - 1'b1;
                  if (cnt == CNT_ONE && ph_q == PH_MSG_IN) begin
                     st    <= S_PAUSE;
                     irq_q <= 1'b1;
                     irq_c <= IRQ_PAUSE;
                  end else begin
                     ack_q <= 1'b0;
                     oe_q  <= 1'b0;
                     st    <= (cnt == CNT_ONE) ? S_DONE : S_XFER;
                  end
               end
               S_DONE: if (req_i) begin
                  st    <= S_IDLE;
                  ph_q  <= ph_bus;
                  irq_q <= 1'b1;
                  irq_c <= IRQ_DONE;
               end
               S_PAUSE, S_PHELD: if (ack_rel) begin
                  ack_q <= 1'b0;
                  st    <= S_WAIT1;
               end
               S_PHALT: if (f_empty) begin
                  st    <= S_PHELD;
                  irq_q <= 1'b1;
                  irq_c <= IRQ_TERM;
               end
               default: st <= S_DISC;
            endcase
         end
      end
   end

   assign cnt_out   = cnt;
   assign h_rdata   = f_rdata;
   assign dbr       = dir_in ? !f_empty : !f_full;
   assign par_err   = perr_q;
   assign irq_v     = irq_q;
   assign irq_code  = irq_c;
   assign connected = (st != S_DISC);
   assign ack_o     = ack_q;
   assign atn_o     = atn_q;
   assign db_o      = dout_q;
   assign dbp_o     = pout_q;
   assign db_oe     = oe_q;

   AST_DATA_BEFORE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ack_o) && !dir_in) |-> (db_oe && $past(db_oe))); // R12
   AST_PAUSE_HOLDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_v && irq_code == IRQ_PAUSE) |-> ack_o); // R6
   AST_PAUSE_UNTIL_REL: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_PAUSE && !ack_rel && !abort) |=> ack_o); // R6
   AST_HALT_KEEPS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_PHALT && !abort) |=> ack_o); // R8
   AST_DISC_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_disc && st != S_DISC) |=> (!irq_v && !connected)); // R10
   AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_v && irq_code == IRQ_DONE) |-> ($past(req_i) && $past(cnt_out) == '0)); // R5
   AST_FULL_HOLDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_XFER && dir_in && f_full) |=> !ack_o); // R11
endmodule

// File: tb/xfer_info_ctl_tb_top.sv
module xfer_info_ctl_tb_top;
   localparam int DW = 8;
   localparam int CW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic conn_i = 0, cmd_go = 0, cmd_single = 0, cmd_disc = 0, ack_rel = 0;
   logic halt_par_en = 0, host_atn = 0, cnt_ld = 0;
   logic [CW-1:0] cnt_in = '0, cnt_out;
   logic h_wr = 0, h_rd = 0;
   logic [DW-1:0] h_wdata = '0, h_rdata, db_i = '0, db_o;
   logic dbr, par_err, irq_v, connected, ack_o, atn_o, dbp_o, db_oe;
   logic [2:0] irq_code;
   logic req_i = 0, bsy_i = 0, cd_i = 0, msg_i = 0, io_i = 0, dbp_i = 0;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   xfer_info_ctl #(.DW(DW), .DEPTH(4), .CNT_W(CW)) dut_i (
      .clk(clk), .rst_n(rst_n), .conn_i(conn_i), .cmd_go(cmd_go),
      .cmd_single(cmd_single), .cmd_disc(cmd_disc), .ack_rel(ack_rel),
      .halt_par_en(halt_par_en), .host_atn(host_atn), .cnt_ld(cnt_ld),
      .cnt_in(cnt_in), .cnt_out(cnt_out), .h_wr(h_wr), .h_wdata(h_wdata),
      .h_rd(h_rd), .h_rdata(h_rdata), .dbr(dbr), .par_err(par_err),
      .irq_v(irq_v), .irq_code(irq_code), .connected(connected),
      .req_i(req_i), .bsy_i(bsy_i), .cd_i(cd_i), .msg_i(msg_i), .io_i(io_i),
      .db_i(db_i), .dbp_i(dbp_i), .ack_o(ack_o), .atn_o(atn_o),
      .db_o(db_o), .dbp_o(dbp_o), .db_oe(db_oe)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic set_ph(input logic [2:0] p);
      {cd_i, msg_i, io_i} = p;
   endtask

   task automatic put_byte(input logic [7:0] d, input bit bad);
      db_i  = d;
      dbp_i = (~^d) ^ bad;
   endtask

   task automatic in_byte(input logic [7:0] d, input bit bad);
      put_byte(d, bad);
      req_i = 1; tick();
      req_i = 0; tick();
   endtask

   task automatic connect_svc(input logic [2:0] p);
      bsy_i = 1; conn_i = 1; tick(); conn_i = 0;
      set_ph(p); req_i = 1; tick();
      chk("R2 svc pulse", irq_v, 1);
      chk("R2 svc code", irq_code, 1);
      tick();
      chk("R2 pulse one cycle", irq_v, 0);
   endtask

   task automatic t_reset();
      chk("R1 disconnected", connected, 0);
      chk("R1 ack low", ack_o, 0);
      chk("R1 atn low", atn_o, 0);
      chk("R1 no irq", irq_v, 0);
      chk("R1 dbr out empty", dbr, 1);
   endtask

   task automatic t_data_in();
      connect_svc(3'b001);
      cnt_ld = 1; cnt_in = 2; tick(); cnt_ld = 0;
      cmd_go = 1; tick(); cmd_go = 0;
      chk("R4 in empty dbr", dbr, 0);
      put_byte(8'hA5, 0); tick();
      chk("R3 ack first byte", ack_o, 1);
      chk("R4 in dbr data", dbr, 1);
      req_i = 0; tick();
      chk("R3 ack drop", ack_o, 0);
      chk("R3 count 1", cnt_out, 1);
      in_byte(8'h3C, 0);
      chk("R5 count zero", cnt_out, 0);
      chk("R5 ack low after last", ack_o, 0);
      tick(); tick();
      chk("R5 no done without req", irq_v, 0);
      set_ph(3'b011); req_i = 1; tick();
      chk("R5 done pulse", irq_v, 1);
      chk("R5 done code", irq_code, 2);
      chk("R4 data byte 1", h_rdata, 8'hA5);
      h_rd = 1; tick(); h_rd = 0;
      chk("R4 data byte 2", h_rdata, 8'h3C);
      h_rd = 1; tick(); h_rd = 0;
   endtask

   task automatic t_data_out_single();
      set_ph(3'b000);
      req_i = 0; tick();
      cnt_ld = 1; cnt_in = 5; tick(); cnt_ld = 0;
      cmd_go = 1; cmd_single = 1; tick(); cmd_go = 0; cmd_single = 0;
      chk("R4 out dbr", dbr, 1);
      req_i = 1; tick(); tick();
      chk("R11 empty no data", db_oe, 0);
      chk("R11 empty no ack", ack_o, 0);
      h_wr = 1; h_wdata = 8'h5A; tick(); h_wr = 0;
      chk("R11 write edge no data", db_oe, 0);
      tick();
      chk("R12 data driven", db_o, 8'h5A);
      chk("R12 parity", dbp_o, ~^8'h5A);
      chk("R12 oe", db_oe, 1);
      chk("R12 ack not yet", ack_o, 0);
      tick();
      chk("R12 ack after data", ack_o, 1);
      req_i = 0; tick();
      chk("R3 single byte count", cnt_out, 0);
      chk("R3 single done ack low", ack_o, 0);
      set_ph(3'b111); req_i = 1; tick();
      chk("R5 done on msg-in req", irq_code, 2);
   endtask

   task automatic t_msg_in();
      cmd_go = 1; cmd_single = 1; tick(); cmd_go = 0; cmd_single = 0;
      put_byte(8'h07, 0); tick();
      chk("R6 ack", ack_o, 1);
      req_i = 0; tick();
      chk("R6 paused pulse", irq_v, 1);
      chk("R6 paused code", irq_code, 3);
      chk("R6 ack held", ack_o, 1);
      host_atn = 1; tick();
      chk("R6 atn out", atn_o, 1);
      chk("R6 ack still held", ack_o, 1);
      ack_rel = 1; tick(); ack_rel = 0;
      chk("R6 ack released", ack_o, 0);
      host_atn = 0;
      chk("R6 msg byte", h_rdata, 8'h07);
      h_rd = 1; tick(); h_rd = 0;
   endtask

   task automatic t_phase_change();
      set_ph(3'b001); req_i = 1; tick();
      chk("R2 svc after pause", irq_code, 1);
      cnt_ld = 1; cnt_in = 3; tick(); cnt_ld = 0;
      cmd_go = 1; tick(); cmd_go = 0;
      put_byte(8'h11, 0); tick();
      req_i = 0; tick();
      set_ph(3'b011); req_i = 1; tick();
      chk("R7 term pulse", irq_v, 1);
      chk("R7 term code", irq_code, 4);
      chk("R7 remaining count", cnt_out, 2);
      chk("R7 no ack", ack_o, 0);
      h_rd = 1; tick(); h_rd = 0;
   endtask

   task automatic t_par_halt();
      halt_par_en = 1;
      cnt_ld = 1; cnt_in = 2; tick(); cnt_ld = 0;
      cmd_go = 1; tick(); cmd_go = 0;
      in_byte(8'h22, 0);
      put_byte(8'h33, 1); req_i = 1; tick();
      chk("R8 ack on halt", ack_o, 1);
      chk("R8 perr", par_err, 1);
      chk("R8 no irq before drain", irq_v, 0);
      tick();
      chk("R8 wait drain", irq_v, 0);
      chk("R8 good byte kept", h_rdata, 8'h22);
      h_rd = 1; tick(); h_rd = 0;
      chk("R8 read edge no irq", irq_v, 0);
      tick();
      chk("R8 term pulse", irq_v, 1);
      chk("R8 term code", irq_code, 4);
      chk("R8 count excludes bad", cnt_out, 1);
      chk("R8 ack still held", ack_o, 1);
      ack_rel = 1; tick(); ack_rel = 0;
      chk("R8 ack released", ack_o, 0);
      halt_par_en = 0; req_i = 0; tick();
   endtask

   task automatic t_par_cont();
      set_ph(3'b001); req_i = 1; tick();
      chk("R2 svc after halt", irq_code, 1);
      cmd_go = 1; cmd_single = 1; tick(); cmd_go = 0; cmd_single = 0;
      chk("R9 perr cleared by cmd", par_err, 0);
      put_byte(8'h44, 1); tick();
      chk("R9 ack despite error", ack_o, 1);
      req_i = 0; tick();
      chk("R9 sticky perr", par_err, 1);
      chk("R9 transfer finished", cnt_out, 0);
      set_ph(3'b011); req_i = 1; tick();
      chk("R9 done code", irq_code, 2);
      chk("R9 byte stored", h_rdata, 8'h44);
      h_rd = 1; tick(); h_rd = 0;
   endtask

   task automatic t_full_and_bsy();
      cnt_ld = 1; cnt_in = 6; tick(); cnt_ld = 0;
      cmd_go = 1; tick(); cmd_go = 0;
      for (int i = 0; i < 4; i++) in_byte(8'h50 + 8'(i), 0);
      chk("R11 count after four", cnt_out, 2);
      put_byte(8'h99, 0); req_i = 1; tick();
      chk("R11 full no ack", ack_o, 0);
      tick();
      chk("R11 still no ack", ack_o, 0);
      chk("R11 head byte", h_rdata, 8'h50);
      h_rd = 1; tick(); h_rd = 0;
      chk("R11 read edge no ack", ack_o, 0);
      tick();
      chk("R11 ack after space", ack_o, 1);
      bsy_i = 0; tick();
      chk("R10 bus free pulse", irq_v, 1);
      chk("R10 bus free code", irq_code, 5);
      chk("R10 disconnected", connected, 0);
      chk("R10 ack dropped", ack_o, 0);
      req_i = 0; tick();
   endtask

   task automatic t_disc();
      connect_svc(3'b001);
      req_i = 0;
      cmd_disc = 1; tick(); cmd_disc = 0;
      chk("R10 disc no irq", irq_v, 0);
      chk("R10 disc disconnected", connected, 0);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      #2000000;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
   end

   initial begin
      tick(); tick();
      rst_n = 1;
      tick();
      t_reset();
      t_data_in();
      t_data_out_single();
      t_msg_in();
      t_phase_change();
      t_par_halt();
      t_par_cont();
      t_full_and_bsy();
      t_disc();
      tick();
      finish_run();
   end
endmodule